// File: doc/BRIEF.md
# Memory Word SEC-DED Encoder and Corrector

This block guards 16-bit memory words with a single-error-correcting, double-error-detecting Hamming code. A memory controller runs it in one of two modes, picked per word by a control input. In generate mode it works out a 6-bit check word for the data about to be written, so that both can be stored side by side. In correct mode it takes the 22 stored bits, computes a 6-bit syndrome, and returns the repaired data along with error flags and the raw syndrome.

A flipped data bit is repaired on the way out. A flipped check bit is reported, but the stored check bits are passed back unchanged and the data is not altered. Every single-bit fault, in either the data or the check field, gives its own syndrome value, so software can locate the failing cell. Two flipped bits, or a syndrome that names a position that does not exist, raise the uncorrectable flag and leave the data untouched. All outputs come from one register stage, so each result appears one cycle after the word is presented.

Top module: `edac_secded`

## Requirements
- R1: In generate mode (`modeCorrect`=0), one cycle after a word is accepted, `checkOut` holds the check word for `dataIn` and `dataOut` echoes `dataIn`. Code layout: the 21 Hamming positions are numbered 1 to 21. Check bit i (i = 0 to 4) sits at position 2^i. The data bits fill the remaining positions in ascending order, with data bit 0 at position 3. Check bit i is the even parity over the positions whose index has bit i set. Check bit 5 makes the XOR of all 16 data bits and all 6 check bits equal to zero.
- R2: In generate mode, `singleErr`, `doubleErr` and `checkBitErr` are low and `syndrome` is zero.
- R3: In correct mode, a word stored without error gives a zero syndrome and no flags, and returns its data unchanged.
- R4: In correct mode, a single flipped data bit at Hamming position p gives `syndrome` = {1, p[4:0]}, `singleErr`=1, `checkBitErr`=0, `doubleErr`=0, and `dataOut` equal to the original data.
- R5: In correct mode, a single flipped check bit i gives `singleErr`=1 and `checkBitErr`=1. The syndrome is {1, 2^i} for i < 5 and 6'b100000 for i = 5. `dataOut` equals `dataIn` and `checkOut` equals `checkIn`, uncorrected.
- R6: In correct mode, any two flipped bits among the 22 give `doubleErr`=1 with `singleErr`=0 and `checkBitErr`=0. `dataOut` equals the received data uncorrected, and `syndrome` bit 5 is 0.
- R7: In correct mode, a syndrome with bit 5 set whose low five bits are between 22 and 31 gives `doubleErr`=1 and `singleErr`=0, with the data left uncorrected.
- R8: `validOut` is high exactly in the cycle after a cycle with `validIn` high. While `validIn` is low, the data, check, syndrome and flag outputs hold their values.
- R9: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCorrect | input | 1 | 0 = generate check word, 1 = check and correct |
| validIn | input | 1 | Input word is present this cycle |
| dataIn | input | 16 | Data word (to write, or as read) |
| checkIn | input | 6 | Check word as read (used in correct mode) |
| dataOut | output | 16 | Echoed or corrected data |
| checkOut | output | 6 | Computed check word, or stored check word passed through |
| syndrome | output | 6 | Raw syndrome, bit 5 = overall parity mismatch |
| singleErr | output | 1 | A single-bit error was found |
| doubleErr | output | 1 | An uncorrectable error was found |
| checkBitErr | output | 1 | The single-bit error lies in the check field |
| validOut | output | 1 | Outputs carry a new result |

## Verification
Generate mode is driven with all-zero, all-one, alternating and random data. Each case shows whether every check bit covers the right set of data positions. Clean round trips show that encoding and checking agree. A flip of each of the 22 positions in turn tests syndrome uniqueness and separates repaired data bits from check bits that are only flagged. Random double flips, and a triple flip that points past position 21, show that uncorrectable words are never "repaired". Idle cycles with changing inputs show that the output register holds.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DATA_W = 16;
  localparam int HAM_W  = 5;
  localparam int CHK_W  = HAM_W + 1;

  typedef struct packed {
    logic load;
    logic genSel;
  } edac_strobe_t;

  // Hamming position of data bit idx: the idx-th non-power-of-two index from 3 up.
  function automatic int unsigned dataPos(int unsigned idx, int unsigned hamW);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p < (32'd1 << hamW); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/edac_parity_gen.sv
module edac_parity_gen #(
  parameter int DATA_W = edac_pkg::DATA_W,
  parameter int HAM_W  = edac_pkg::HAM_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W-1:0]  hamPar
);
  function automatic logic [DATA_W-1:0] coverMask(int unsigned bitIdx);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < DATA_W; k++) begin
      m[k] = ((edac_pkg::dataPos(k, HAM_W) >> bitIdx) & 1) != 0;
    end
    return m;
  endfunction

  for (genvar i = 0; i < HAM_W; i++) begin : g_par
    localparam logic [DATA_W-1:0] MASK = coverMask(i);
    assign hamPar[i] = ^(data & MASK);
  end
endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode #(
  parameter int DATA_W = edac_pkg::DATA_W,
  parameter int HAM_W  = edac_pkg::HAM_W,
  localparam int CHK_W = HAM_W + 1,
  localparam int CODE_LEN = DATA_W + HAM_W
) (
  input  logic [CHK_W-1:0]  syn,
  input  logic [DATA_W-1:0] dataRaw,
  output logic [DATA_W-1:0] dataFixed,
  output logic              dataErr,
  output logic              chkErr,
  output logic              dblErr
);
  logic [HAM_W-1:0]  hamSyn;
  logic              ovr, hamZero, hamPow2, inRange;
  logic [DATA_W-1:0] flipMask;

  assign hamSyn  = syn[HAM_W-1:0];
  assign ovr     = syn[HAM_W];
  assign hamZero = (hamSyn == '0);
  assign hamPow2 = !hamZero && ((hamSyn & (hamSyn - 1'b1)) == '0);
  assign inRange = (int'(hamSyn) <= CODE_LEN);

  assign chkErr  = ovr && (hamZero || hamPow2);
  assign dataErr = ovr && !hamZero && !hamPow2 && inRange;
  assign dblErr  = (!ovr && !hamZero) || (ovr && !inRange);

  for (genvar k = 0; k < DATA_W; k++) begin : g_flip
    localparam int unsigned POS = edac_pkg::dataPos(k, HAM_W);
    assign flipMask[k] = dataErr && (int'(hamSyn) == int'(POS));
  end

  assign dataFixed = dataRaw ^ flipMask;

  always_comb begin
    assert_decode_exclusive_R6: assert (!(dblErr && (dataErr || chkErr)) && !(dataErr && chkErr));
  end
endmodule

// File: rtl/edac_control.sv
module edac_control (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   modeCorrect,
  input  logic                   validIn,
  output edac_pkg::edac_strobe_t strb,
  output logic                   validOut
);
  logic validQ;

  assign strb.load   = validIn;
  assign strb.genSel = !modeCorrect;
  assign validOut    = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= validIn;
  end

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/edac_datapath.sv
module edac_datapath #(
  parameter int DATA_W = edac_pkg::DATA_W,
  parameter int HAM_W  = edac_pkg::HAM_W,
  localparam int CHK_W = HAM_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  edac_pkg::edac_strobe_t strb,
  input  logic [DATA_W-1:0]      dataIn,
  input  logic [CHK_W-1:0]       checkIn,
  output logic [DATA_W-1:0]      dataOut,
  output logic [CHK_W-1:0]       checkOut,
  output logic [CHK_W-1:0]       syndrome,
  output logic                   singleErr,
  output logic                   doubleErr,
  output logic                   checkBitErr
);
  logic [HAM_W-1:0]  hamPar;
  logic [CHK_W-1:0]  genCheck, rdSyn;
  logic [DATA_W-1:0] dataFixed;
  logic              dataErr, chkErr, dblErr;

  edac_parity_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_par (
    .data   (dataIn),
    .hamPar (hamPar)
  );

  assign genCheck = {(^dataIn) ^ (^hamPar), hamPar};
  assign rdSyn    = {(^dataIn) ^ (^checkIn), hamPar ^ checkIn[HAM_W-1:0]};

  edac_syn_decode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .syn       (rdSyn),
    .dataRaw   (dataIn),
    .dataFixed (dataFixed),
    .dataErr   (dataErr),
    .chkErr    (chkErr),
    .dblErr    (dblErr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut     <= '0;
      checkOut    <= '0;
      syndrome    <= '0;
      singleErr   <= 1'b0;
      doubleErr   <= 1'b0;
      checkBitErr <= 1'b0;
    end else if (strb.load) begin
      if (strb.genSel) begin
        dataOut     <= dataIn;
        checkOut    <= genCheck;
        syndrome    <= '0;
        singleErr   <= 1'b0;
        doubleErr   <= 1'b0;
        checkBitErr <= 1'b0;
      end else begin
        dataOut     <= dataFixed;
        checkOut    <= checkIn;
        syndrome    <= rdSyn;
        singleErr   <= dataErr || chkErr;
        doubleErr   <= dblErr;
        checkBitErr <= chkErr;
      end
    end
  end

  assert_gen_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.genSel) |=> (!singleErr && !doubleErr && !checkBitErr && syndrome == '0));
  assert_check_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.genSel) |=> (checkOut == $past(checkIn)));
  assert_single_fix_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.genSel && dataErr) |=> ($countones(dataOut ^ $past(dataIn)) == 1));
  assert_double_nofix_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.genSel && dblErr) |=> (dataOut == $past(dataIn)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(dataOut) && $stable(syndrome) && $stable(checkOut)));
  assert_flag_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    checkBitErr |-> (singleErr && !doubleErr));
  assert_zero_syn_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    (syndrome == '0) |-> (!singleErr && !doubleErr));
endmodule

// File: rtl/edac_secded.sv
module edac_secded #(
  parameter int DATA_W = edac_pkg::DATA_W,
  parameter int HAM_W  = edac_pkg::HAM_W,
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCorrect,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CHK_W-1:0]  checkIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CHK_W-1:0]  checkOut,
  output logic [CHK_W-1:0]  syndrome,
  output logic              singleErr,
  output logic              doubleErr,
  output logic              checkBitErr,
  output logic              validOut
);
  edac_pkg::edac_strobe_t strb;

  edac_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeCorrect (modeCorrect),
    .validIn     (validIn),
    .strb        (strb),
    .validOut    (validOut)
  );

  edac_datapath #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dataIn      (dataIn),
    .checkIn     (checkIn),
    .dataOut     (dataOut),
    .checkOut    (checkOut),
    .syndrome    (syndrome),
    .singleErr   (singleErr),
    .doubleErr   (doubleErr),
    .checkBitErr (checkBitErr)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |-> (!validOut && !singleErr && !doubleErr && dataOut == '0));
endmodule

// File: tb/edac_secded_tb.sv
`timescale 1ns/1ps
module edac_secded_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeCorrect = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] dataIn = '0;
  logic [5:0]  checkIn = '0;
  logic [15:0] dataOut;
  logic [5:0]  checkOut, syndrome;
  logic        singleErr, doubleErr, checkBitErr, validOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] obsData;
  logic [5:0]  obsCheck, obsSyn;
  logic        obsSingle, obsDouble, obsChk, obsValid;

  always #2.5 clk = ~clk;

  edac_secded dut_i (
    .clk(clk), .rstN(rstN), .modeCorrect(modeCorrect), .validIn(validIn),
    .dataIn(dataIn), .checkIn(checkIn), .dataOut(dataOut), .checkOut(checkOut),
    .syndrome(syndrome), .singleErr(singleErr), .doubleErr(doubleErr),
    .checkBitErr(checkBitErr), .validOut(validOut)
  );

  function automatic int posOfData(int idx);
    int cnt = 0;
    for (int p = 3; p <= 21; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [5:0] refEncode(logic [15:0] d);
    logic [21:0] code;
    logic [5:0]  c;
    code = '0;
    for (int k = 0; k < 16; k++) code[posOfData(k)] = d[k];
    for (int i = 0; i < 5; i++) begin
      c[i] = 1'b0;
      for (int p = 1; p <= 21; p++) if (((p >> i) & 1) != 0) c[i] ^= code[p];
    end
    c[5] = (^d) ^ (^c[4:0]);
    return c;
  endfunction

  // Hamming position of flat bit j (0..15 data, 16..21 check)
  function automatic logic [4:0] flatPos(int j);
    if (j < 16) return 5'(posOfData(j));
    if (j < 21) return 5'(1 << (j - 16));
    return 5'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runWord(input logic m, input logic [15:0] d, input logic [5:0] c);
    @(negedge clk);
    modeCorrect = m; dataIn = d; checkIn = c; validIn = 1'b1;
    @(negedge clk);
    obsData = dataOut; obsCheck = checkOut; obsSyn = syndrome;
    obsSingle = singleErr; obsDouble = doubleErr; obsChk = checkBitErr; obsValid = validOut;
    validIn = 1'b0;
  endtask

  task automatic testReset();
    chk(dataOut == 0 && checkOut == 0 && syndrome == 0, "R9 data/check/syn", {dataOut, checkOut, syndrome}, 0);
    chk({singleErr, doubleErr, checkBitErr, validOut} == 0, "R9 flags", {singleErr, doubleErr, checkBitErr, validOut}, 0);
  endtask

  task automatic testGenerate();
    logic [15:0] pats[5] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h1234};
    for (int n = 0; n < 9; n++) begin
      logic [15:0] d = (n < 5) ? pats[n] : 16'($urandom());
      runWord(1'b0, d, 6'h3F);
      chk(obsCheck == refEncode(d), "R1 check word", obsCheck, refEncode(d));
      chk(obsData == d, "R1 data echo", obsData, d);
      chk({obsSingle, obsDouble, obsChk} == 0 && obsSyn == 0, "R2 quiet", {obsSingle, obsDouble, obsChk, obsSyn}, 0);
      chk(obsValid == 1'b1, "R8 valid after load", obsValid, 1);
    end
  endtask

  task automatic testRoundTrip();
    for (int n = 0; n < 6; n++) begin
      logic [15:0] d = 16'($urandom());
      logic [5:0]  c;
      runWord(1'b0, d, 6'h00);
      c = obsCheck;
      runWord(1'b1, d, c);
      chk(obsSyn == 0, "R3 zero syndrome", obsSyn, 0);
      chk({obsSingle, obsDouble, obsChk} == 0, "R3 no flags", {obsSingle, obsDouble, obsChk}, 0);
      chk(obsData == d, "R3 data", obsData, d);
    end
  endtask

  task automatic testSingleFlips();
    for (int rep = 0; rep < 2; rep++) begin
      logic [15:0] d = 16'($urandom());
      logic [5:0]  c = refEncode(d);
      for (int j = 0; j < 22; j++) begin
        logic [21:0] w = {c, d} ^ (22'd1 << j);
        logic [5:0]  expSyn = {1'b1, flatPos(j)};
        runWord(1'b1, w[15:0], w[21:16]);
        if (j < 16) begin
          chk(obsSyn == expSyn, "R4 syndrome", obsSyn, expSyn);
          chk(obsSingle && !obsChk && !obsDouble, "R4 flags", {obsSingle, obsChk, obsDouble}, 3'b100);
          chk(obsData == d, "R4 corrected data", obsData, d);
        end else begin
          chk(obsSyn == expSyn, "R5 syndrome", obsSyn, expSyn);
          chk(obsSingle && obsChk && !obsDouble, "R5 flags", {obsSingle, obsChk, obsDouble}, 3'b110);
          chk(obsData == d, "R5 data unchanged", obsData, d);
          chk(obsCheck == w[21:16], "R5 check not corrected", obsCheck, w[21:16]);
        end
      end
    end
  endtask

  task automatic testDoubleFlips();
    for (int n = 0; n < 40; n++) begin
      logic [15:0] d = 16'($urandom());
      int a = $urandom_range(21, 0);
      int b = $urandom_range(20, 0);
      logic [21:0] w;
      if (b >= a) b++;
      w = {refEncode(d), d} ^ (22'd1 << a) ^ (22'd1 << b);
      runWord(1'b1, w[15:0], w[21:16]);
      chk(obsDouble && !obsSingle && !obsChk, "R6 flags", {obsDouble, obsSingle, obsChk}, 3'b100);
      chk(obsData == w[15:0], "R6 data uncorrected", obsData, w[15:0]);
      chk(obsSyn[5] == 1'b0, "R6 syndrome bit 5", obsSyn, 0);
    end
  endtask

  task automatic testBadPointer();
    logic [15:0] d = 16'hC3A5;
    logic [5:0]  c = refEncode(d) ^ 6'b010110;
    runWord(1'b1, d, c);
    chk(obsSyn == 6'b110110, "R7 syndrome", obsSyn, 6'b110110);
    chk(obsDouble && !obsSingle && !obsChk, "R7 flags", {obsDouble, obsSingle, obsChk}, 3'b100);
    chk(obsData == d, "R7 data uncorrected", obsData, d);
  endtask

  task automatic testValidHold();
    logic [15:0] d = 16'h0F0F;
    logic [21:0] w = {refEncode(d), d} ^ 22'd1;
    runWord(1'b1, w[15:0], w[21:16]);
    @(negedge clk);
    modeCorrect = 1'b0; dataIn = 16'hDEAD; checkIn = 6'h15;
    chk(validOut == 1'b0, "R8 valid drops", validOut, 0);
    repeat (3) @(negedge clk);
    chk(dataOut == obsData && syndrome == obsSyn && checkOut == obsCheck, "R8 hold",
        {dataOut, syndrome, checkOut}, {obsData, obsSyn, obsCheck});
    chk(singleErr == obsSingle && validOut == 1'b0, "R8 hold flags", {singleErr, validOut}, {obsSingle, 1'b0});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c));
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testGenerate();
    testRoundTrip();
    testSingleFlips();
    testDoubleFlips();
    testBadPointer();
    testValidHold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule